// File: doc/BRIEF.md
# Start Pulse Prescaler

This block sits between an external start pulse stream and a time-measurement core. The external start is already synchronised to the core clock and arrives as a level. The block finds its rising edges and sends a reduced-rate stream of start strobes onward, so that a fast source (up to 150 MHz) reaches the core below 9 MHz. For example, an 80 MHz source needs a divide setting of 16. Stop events do not pass through this block and are never filtered by it.

A configuration input selects the divide setting. With a divide setting X, only the first edge of each run of X edges is forwarded. A setting of zero passes every edge through. Illegal settings fall back to pass-through and raise a sticky error flag. When the internally generated start is selected, it is forwarded as-is and is never divided.

Each forwarded start produces a one-cycle strobe. The block also keeps a phase index: the position of the latest external edge inside its group. Downstream logic can tag stops with this index and fold the delayed copies of the time histogram back together by modulo.

Top module: `start_prescaler`

## Requirements
- R1: `div_cfg_i` is a 6-bit unsigned setting. The legal values are 0, 2, 4, 8, 16 and 32. Every other value, including 1, is invalid.
- R2: With `ext_sel_i` high and a setting of 0, every rising edge of `start_i` gives a one-cycle `start_accept_o` pulse. The pulse appears in the cycle after the clock edge that first samples `start_i` high, and `phase_o` is 0 at that point.
- R3: An invalid setting behaves like setting 0: every edge is forwarded with phase 0. In addition, `cfg_error_o` goes high in the cycle after the invalid value is applied. It stays high until a legal value is applied, and drops one cycle after that.
- R4: With a legal setting X > 0, external edges are numbered n = 0, 1, 2, … from the last counter restart. Edge n is forwarded if and only if n mod X = 0. All other edges produce no strobe.
- R5: Under division, after each external edge `phase_o` equals n mod X from the following cycle onward. It holds that value until the next edge or forwarded start.
- R6: With `ext_sel_i` low, each high cycle of `int_start_i` is forwarded one cycle later with phase 0, and is never divided. External edges in this mode give no strobe and leave `phase_o` unchanged. The group count restarts, so the first external edge after switching back is forwarded.
- R7: The group count restarts whenever `div_cfg_i` differs from its value in the previous cycle, or whenever `meas_start_i` is high. An edge in that same cycle is numbered 0.
- R8: After reset, `start_accept_o`, `phase_o` and `cfg_error_o` are all 0. The last-seen setting is taken as 0.
- R9: Only rising edges count. Holding `start_i` high for several cycles yields at most one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Synchronised external start level |
| int_start_i | input | 1 | Internal start strobe, one cycle per start |
| ext_sel_i | input | 1 | 1: external start source, 0: internal |
| div_cfg_i | input | 6 | Divide setting (0, 2, 4, 8, 16, 32) |
| meas_start_i | input | 1 | Measurement start, restarts the group count |
| start_accept_o | output | 1 | One-cycle forwarded start strobe |
| phase_o | output | 5 | Position of the latest edge within its group |
| cfg_error_o | output | 1 | Sticky invalid-setting flag |

## Verification
The assertions take several things for granted. They assume `start_i` is already synchronous to `clk_i`. They assume `int_start_i` matters only while the internal source is selected. They assume the edge detector's history starts cleared, which only makes sense if `start_i` is held low during reset. The stimulus respects all of this. It keeps `start_i` low in reset, changes every input half a period away from the active edge, and gives `int_start_i` only single-cycle pulses. It also sweeps each legal and several illegal settings, switches settings and restarts measurements in the middle of a group, and makes the two events coincide with an edge.

// File: rtl/start_prescaler_pkg.sv
package start_prescaler_pkg;
  typedef enum logic [1:0] {
    MODE_INT    = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_DIV    = 2'd2
  } sp_mode_e;
endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/sp_cfg_decode.sv
module sp_cfg_decode #(
  parameter int unsigned CFG_W   = 6,
  parameter int unsigned MAX_DIV = 32,
  parameter int unsigned CNT_W   = $clog2(MAX_DIV)
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic             legal_o,
  output logic             div_en_o,
  output logic [CNT_W-1:0] last_idx_o
);
  logic is_zero, is_pow2;

  assign is_zero    = (cfg_i == '0);
  assign is_pow2    = ($countones(cfg_i) == 1) && (cfg_i >= CFG_W'(2)) &&
                      (cfg_i <= CFG_W'(MAX_DIV));
  assign legal_o    = is_zero | is_pow2;
  assign div_en_o   = is_pow2;
  assign last_idx_o = CNT_W'(cfg_i - CFG_W'(1));
endmodule

// File: rtl/sp_group_ctr.sv
module sp_group_ctr #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] last_i,
  output logic [CNT_W-1:0] idx_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // a clear takes effect for an edge in the same cycle
  assign idx_o = clr_i ? '0 : cnt_q;

  always_comb begin
    cnt_d = idx_o;
    if (step_i) cnt_d = (idx_o == last_i) ? '0 : idx_o + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/start_prescaler.sv
module start_prescaler
  import start_prescaler_pkg::*;
#(
  parameter int unsigned CFG_W   = 6,
  parameter int unsigned MAX_DIV = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       int_start_i,
  input  logic                       ext_sel_i,
  input  logic [CFG_W-1:0]           div_cfg_i,
  input  logic                       meas_start_i,
  output logic                       start_accept_o,
  output logic [$clog2(MAX_DIV)-1:0] phase_o,
  output logic                       cfg_error_o
);
  localparam int unsigned CNT_W = $clog2(MAX_DIV);

  logic             ext_edge;
  logic             legal, div_en;
  logic [CNT_W-1:0] last_idx, grp_idx;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg, grp_clr, grp_step;
  sp_mode_e         mode;
  logic             fwd, ph_upd;
  logic [CNT_W-1:0] ph_new;

  sp_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (start_i),
    .rise_o (ext_edge)
  );

  sp_cfg_decode #(.CFG_W(CFG_W), .MAX_DIV(MAX_DIV), .CNT_W(CNT_W)) u_dec (
    .cfg_i      (div_cfg_i),
    .legal_o    (legal),
    .div_en_o   (div_en),
    .last_idx_o (last_idx)
  );

  assign cfg_chg = (div_cfg_i != cfg_q);

  always_comb begin
    if (!ext_sel_i)  mode = MODE_INT;
    else if (div_en) mode = MODE_DIV;
    else             mode = MODE_BYPASS;
  end

  assign grp_clr  = (mode != MODE_DIV) | cfg_chg | meas_start_i;
  assign grp_step = (mode == MODE_DIV) & ext_edge;

  sp_group_ctr #(.CNT_W(CNT_W)) u_grp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (grp_clr),
    .step_i (grp_step),
    .last_i (last_idx),
    .idx_o  (grp_idx)
  );

  always_comb begin
    fwd    = 1'b0;
    ph_upd = 1'b0;
    ph_new = '0;
    unique case (mode)
      MODE_INT: begin
        fwd    = int_start_i;
        ph_upd = int_start_i;
      end
      MODE_BYPASS: begin
        fwd    = ext_edge;
        ph_upd = ext_edge;
      end
      MODE_DIV: begin
        fwd    = ext_edge & (grp_idx == '0);
        ph_upd = ext_edge;
        ph_new = grp_idx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q          <= '0;
      start_accept_o <= 1'b0;
      phase_o        <= '0;
      cfg_error_o    <= 1'b0;
    end else begin
      cfg_q          <= div_cfg_i;
      start_accept_o <= fwd;
      if (ph_upd)  phase_o     <= ph_new;
      if (cfg_chg) cfg_error_o <= ~legal;
    end
  end
endmodule

// File: rtl/start_prescaler_chk.sv
module start_prescaler_chk #(
  parameter int unsigned CFG_W   = 6,
  parameter int unsigned MAX_DIV = 32
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       int_start_i,
  input logic                       ext_sel_i,
  input logic [CFG_W-1:0]           div_cfg_i,
  input logic                       meas_start_i,
  input logic                       ext_edge,
  input logic                       start_accept_o,
  input logic [$clog2(MAX_DIV)-1:0] phase_o,
  input logic                       cfg_error_o
);
  logic cfg_ok;
  assign cfg_ok = (div_cfg_i == '0) ||
                  (($countones(div_cfg_i) == 1) && (div_cfg_i >= CFG_W'(2)) &&
                   (div_cfg_i <= CFG_W'(MAX_DIV)));

  p_bypass_fwd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && div_cfg_i == '0 && ext_edge) |=> start_accept_o);

  p_invalid_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && !cfg_ok && ext_edge) |=> (start_accept_o && cfg_error_o));

  p_accept_phase_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_accept_o |-> (phase_o == '0));

  p_int_fwd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_sel_i && int_start_i) |=> start_accept_o);

  p_int_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext_sel_i && !int_start_i) |=> !start_accept_o);

  p_restart_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && meas_start_i && ext_edge) |=> start_accept_o);

  p_no_edge_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && !ext_edge) |=> !start_accept_o);
endmodule

bind start_prescaler start_prescaler_chk #(.CFG_W(CFG_W), .MAX_DIV(MAX_DIV)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .int_start_i    (int_start_i),
  .ext_sel_i      (ext_sel_i),
  .div_cfg_i      (div_cfg_i),
  .meas_start_i   (meas_start_i),
  .ext_edge       (ext_edge),
  .start_accept_o (start_accept_o),
  .phase_o        (phase_o),
  .cfg_error_o    (cfg_error_o)
);

// File: tb/start_prescaler_tb_top.sv
module start_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       int_start_i = 1'b0;
  logic       ext_sel_i = 1'b1;
  logic [5:0] div_cfg_i = 6'd0;
  logic       meas_start_i = 1'b0;
  logic       start_accept_o;
  logic [4:0] phase_o;
  logic       cfg_error_o;

  always #5 clk = ~clk;

  start_prescaler dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .int_start_i    (int_start_i),
    .ext_sel_i      (ext_sel_i),
    .div_cfg_i      (div_cfg_i),
    .meas_start_i   (meas_start_i),
    .start_accept_o (start_accept_o),
    .phase_o        (phase_o),
    .cfg_error_o    (cfg_error_o)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string req = "R8";

  // reference model state
  int m_prev = 0, m_cfg = 0, m_n = 0, e_acc = 0, e_ph = 0, e_err = 0;

  function automatic bit legal(int c);
    return c == 0 || c == 2 || c == 4 || c == 8 || c == 16 || c == 32;
  endfunction

  task automatic model();
    int  c;
    bit  edg, chg;
    if (!rst_ni) begin
      m_prev = 0; m_cfg = 0; m_n = 0; e_acc = 0; e_ph = 0; e_err = 0;
      return;
    end
    c   = int'(div_cfg_i);
    edg = start_i && !m_prev;
    chg = (c != m_cfg);
    e_acc = 0;
    if (!ext_sel_i) begin
      m_n = 0;
      if (int_start_i) begin e_acc = 1; e_ph = 0; end
    end else if (!legal(c) || c == 0) begin
      m_n = 0;
      if (edg) begin e_acc = 1; e_ph = 0; end
    end else begin
      if (chg || meas_start_i) m_n = 0;
      if (edg) begin
        e_ph  = m_n % c;
        e_acc = (e_ph == 0);
        m_n   = m_n + 1;
      end
    end
    if (chg) e_err = !legal(c);
    m_cfg  = c;
    m_prev = start_i;
  endtask

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model();
    @(negedge clk);
    chk("start_accept_o", int'(start_accept_o), e_acc);
    chk("phase_o", int'(phase_o), e_ph);
    chk("cfg_error_o", int'(cfg_error_o), e_err);
  endtask

  task automatic pulses(int cnt, int hi, int lo);
    for (int i = 0; i < cnt; i++) begin
      start_i = 1'b1;
      repeat (hi) tick();
      start_i = 1'b0;
      repeat (lo) tick();
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R8: reset state
    req = "R8";
    repeat (3) tick();
    @(negedge clk);
    rst_ni = 1'b1;
    tick();

    // R2: pass-through, several pulse shapes
    req = "R2";
    pulses(5, 1, 1);
    pulses(4, 3, 2);

    // R1 R4 R5: every legal divide setting
    for (int k = 1; k <= 5; k++) begin
      req = "R4";
      div_cfg_i = 6'(1 << k);
      tick();
      req = "R5";
      pulses((2 << k) + 3, 1, 1);
    end
    req = "R1";
    div_cfg_i = 6'd16;
    pulses(20, 2, 1);

    // R9: held level yields one edge
    req = "R9";
    div_cfg_i = 6'd0;
    tick();
    start_i = 1'b1;
    repeat (10) tick();
    start_i = 1'b0;
    tick();

    // R7: restart by measurement start, mid-group and coincident with an edge
    req = "R7";
    div_cfg_i = 6'd8;
    pulses(5, 1, 1);
    meas_start_i = 1'b1; tick(); meas_start_i = 1'b0;
    pulses(5, 1, 1);
    start_i = 1'b1; meas_start_i = 1'b1; tick();
    meas_start_i = 1'b0; start_i = 1'b0; tick();
    pulses(4, 1, 1);
    // setting change coinciding with an edge
    start_i = 1'b1; div_cfg_i = 6'd4; tick();
    start_i = 1'b0; tick();
    pulses(6, 1, 1);

    // R3: invalid settings force pass-through and flag an error
    req = "R3";
    div_cfg_i = 6'd1;  pulses(4, 1, 1);
    div_cfg_i = 6'd3;  pulses(3, 1, 2);
    div_cfg_i = 6'd48; pulses(3, 1, 1);
    div_cfg_i = 6'd63; pulses(2, 1, 1);
    div_cfg_i = 6'd4;  pulses(6, 1, 1);
    div_cfg_i = 6'd0;  pulses(2, 1, 1);

    // R6: internal source, never divided, external edges ignored
    req = "R6";
    div_cfg_i = 6'd8;
    pulses(3, 1, 1);
    ext_sel_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      int_start_i = 1'b1; tick();
      int_start_i = 1'b0; tick();
    end
    pulses(5, 1, 1);
    ext_sel_i = 1'b1;
    pulses(10, 1, 1);

    repeat (3) tick();
    summary();
  end
endmodule